// File: doc/BRIEF.md
# Threshold Window Alarm with Persistence Filter

This block watches a stream of finished 16-bit measurements. Each result that comes with a valid pulse is compared, unsigned, against a programmable lower and upper bound. A result below the lower bound or above the upper bound is outside the window. A counter tracks how many valid results in a row have been outside the window. When that run reaches the length chosen by a 2-bit persistence code, the block raises a sticky status flag and drives an active-low interrupt line.

The flag and the interrupt line stay asserted until the register interface sends a one-cycle clear strobe, which it issues after the status register has been read. An enable input comes from the operating mode. While it is low, the run counter is held at zero and nothing can trigger. All outputs are registered. The reset is synchronous and active high.

Top module: `win_alarm_top`

## Requirements
- R1: After reset, `alarm_flag_o` is 0 and `alarm_n_o` is 1.
- R2: A valid sample is outside the window when it is strictly below `thr_lo_i` or strictly above `thr_hi_i`. The comparison is unsigned. A sample equal to either bound counts as inside.
- R3: Persistence code 0 requires 1 consecutive outside sample, code 1 requires 4, code 2 requires 8 and code 3 requires 16. The flag becomes 1 in the cycle after the valid pulse that completes the run, and not earlier.
- R4: A valid sample inside the window resets the run count to zero.
- R5: `alarm_n_o` is always the inverse of `alarm_flag_o`, so the line is low exactly while the flag is set.
- R6: Once set, the flag and the line hold until a clear strobe. A clear without a trigger in the same cycle drops both in the next cycle.
- R7: While `enable_i` is 0, the run count is held at zero and no trigger occurs. After enable returns, a full run is needed again.
- R8: If a clear strobe and a trigger fall in the same cycle, the trigger wins and the flag stays or becomes 1.
- R9: Cycles without a valid pulse leave the run count unchanged, so outside samples need not arrive on consecutive clock cycles.
- R10: The run count saturates at its maximum. While samples stay outside the window after a run is complete, each further outside sample triggers again, even right after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Measuring mode active; 0 means power-down |
| sample_i | input | 16 | Finished measurement value |
| sample_vld_i | input | 1 | One-cycle pulse qualifying `sample_i` |
| thr_lo_i | input | 16 | Lower window bound |
| thr_hi_i | input | 16 | Upper window bound |
| persist_sel_i | input | 2 | Run-length code (0:1, 1:4, 2:8, 3:16) |
| clear_i | input | 1 | Clear strobe from the register interface, issued after the status read |
| alarm_flag_o | output | 1 | Sticky alarm status, active high |
| alarm_n_o | output | 1 | Interrupt line, active low |

## Verification
The bench builds the block with its default parameters: a 16-bit data path and run lengths of 1, 4, 8 and 16. All four persistence codes can therefore be driven to completion in a few dozen samples. That includes the 15-versus-16 edge of the longest code and saturation of the counter. The 16-bit width places the bound-equality cases and the extremes 0 and FFFFh within the same short sequences.

// File: rtl/win_alarm_pkg.sv
package win_alarm_pkg;
  // Largest of four run lengths; sizes the run counter.
  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/win_compare.sv
module win_compare #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] thr_lo,
  input  logic [DATA_W-1:0] thr_hi,
  output logic              outside
);
  // Bounds themselves are inside the window.
  always_comb outside = (sample < thr_lo) || (sample > thr_hi);
endmodule

// File: rtl/run_counter.sv
module run_counter #(
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned CNT_MAX = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             vld,
  input  logic             outside,
  input  logic [CNT_W-1:0] run_len,
  output logic             trig
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc = (cnt_q >= CNT_W'(CNT_MAX)) ? cnt_q : cnt_q + 1'b1;
    trig    = enable && vld && outside && (cnt_inc >= run_len);
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) cnt_q <= '0;
    else if (vld) cnt_q <= outside ? cnt_inc : '0;
  end

  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> cnt_q == '0);
  assert_inside_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && vld && !outside) |=> cnt_q == '0);
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (enable && !vld) |=> $stable(cnt_q));
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(CNT_MAX));
endmodule

// File: rtl/alarm_latch.sv
module alarm_latch (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic clear,
  output logic flag_q,
  output logic line_n_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q   <= 1'b0;
      line_n_q <= 1'b1;
    end else if (trig) begin
      flag_q   <= 1'b1;
      line_n_q <= 1'b0;
    end else if (clear) begin
      flag_q   <= 1'b0;
      line_n_q <= 1'b1;
    end
  end

  assert_line_tracks_flag_R5: assert property (@(posedge clk) disable iff (rst)
    line_n_q == !flag_q);
  assert_trig_wins_R8: assert property (@(posedge clk) disable iff (rst)
    trig |=> flag_q);
  assert_clear_drops_R6: assert property (@(posedge clk) disable iff (rst)
    (clear && !trig) |=> !flag_q);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clear) |=> flag_q);
endmodule

// File: rtl/win_alarm_top.sv
module win_alarm_top #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LEN0   = 1,
  parameter int unsigned LEN1   = 4,
  parameter int unsigned LEN2   = 8,
  parameter int unsigned LEN3   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_vld_i,
  input  logic [DATA_W-1:0] thr_lo_i,
  input  logic [DATA_W-1:0] thr_hi_i,
  input  logic [1:0]        persist_sel_i,
  input  logic              clear_i,
  output logic              alarm_flag_o,
  output logic              alarm_n_o
);
  import win_alarm_pkg::*;

  localparam int unsigned CNT_MAX = max_of4(LEN0, LEN1, LEN2, LEN3);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam int unsigned LENS [4] = '{LEN0, LEN1, LEN2, LEN3};

  logic [CNT_W-1:0] len_tab [4];
  logic [CNT_W-1:0] run_len;
  logic             outside;
  logic             trig;

  for (genvar g = 0; g < 4; g++) begin : g_len
    assign len_tab[g] = CNT_W'(LENS[g]);
  end

  assign run_len = len_tab[persist_sel_i];

  win_compare #(.DATA_W(DATA_W)) cmp_i (
    .sample (sample_i),
    .thr_lo (thr_lo_i),
    .thr_hi (thr_hi_i),
    .outside(outside)
  );

  run_counter #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) cnt_i (
    .clk    (clk),
    .rst    (rst),
    .enable (enable_i),
    .vld    (sample_vld_i),
    .outside(outside),
    .run_len(run_len),
    .trig   (trig)
  );

  alarm_latch latch_i (
    .clk     (clk),
    .rst     (rst),
    .trig    (trig),
    .clear   (clear_i),
    .flag_q  (alarm_flag_o),
    .line_n_q(alarm_n_o)
  );

  assert_no_trig_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (!enable_i && !alarm_flag_o && !clear_i) |=> !alarm_flag_o);
  assert_bound_inside_R2: assert property (@(posedge clk) disable iff (rst)
    (sample_vld_i && (sample_i == thr_lo_i || sample_i == thr_hi_i) && !alarm_flag_o)
      |=> !alarm_flag_o);
endmodule

// File: tb/win_alarm_top_tb_top.sv
module win_alarm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        enable_i;
  logic [15:0] sample_i;
  logic        sample_vld_i;
  logic [15:0] thr_lo_i;
  logic [15:0] thr_hi_i;
  logic [1:0]  persist_sel_i;
  logic        clear_i;
  logic        alarm_flag_o;
  logic        alarm_n_o;

  always #10 clk = ~clk; // 50 MHz

  win_alarm_top dut_i (
    .clk(clk), .rst(rst), .enable_i(enable_i), .sample_i(sample_i),
    .sample_vld_i(sample_vld_i), .thr_lo_i(thr_lo_i), .thr_hi_i(thr_hi_i),
    .persist_sel_i(persist_sel_i), .clear_i(clear_i),
    .alarm_flag_o(alarm_flag_o), .alarm_n_o(alarm_n_o)
  );

  typedef struct { logic flag; string tag; } exp_t;
  exp_t exp_q [$];
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference state derived from the requirements
  int unsigned m_cnt  = 0;
  logic        m_flag = 1'b0;

  function automatic int unsigned len_of(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  // Driver: apply one cycle of stimulus, predict and push expected result
  task automatic step(input logic v, input logic [15:0] s, input logic clr,
                      input logic en, input string tag);
    logic trig;
    exp_t e;
    @(negedge clk);
    sample_vld_i = v; sample_i = s; clear_i = clr; enable_i = en;
    trig = 1'b0;
    if (!en) m_cnt = 0;
    else if (v) begin
      if (s < thr_lo_i || s > thr_hi_i) begin
        if (m_cnt < 16) m_cnt++;
        trig = (m_cnt >= len_of(persist_sel_i));
      end else m_cnt = 0;
    end
    if (trig) m_flag = 1'b1;
    else if (clr) m_flag = 1'b0;
    @(posedge clk);
    #1;
    e.flag = m_flag; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic cfg(input logic [15:0] lo, input logic [15:0] hi, input logic [1:0] sel);
    @(negedge clk);
    sample_vld_i = 1'b0; clear_i = 1'b0;
    thr_lo_i = lo; thr_hi_i = hi; persist_sel_i = sel;
  endtask

  // Monitor: pop and compare away from the clock edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (alarm_flag_o !== e.flag || alarm_n_o !== !e.flag) begin
        errors++;
        $display("FAIL %s: flag=%b line_n=%b expected flag=%b line_n=%b",
                 e.tag, alarm_flag_o, alarm_n_o, e.flag, !e.flag);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t e0;
    rst = 1'b1; enable_i = 1'b1; sample_i = '0; sample_vld_i = 1'b0;
    thr_lo_i = 16'd100; thr_hi_i = 16'd200; persist_sel_i = 2'd0; clear_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    e0.flag = 1'b0; e0.tag = "R1 reset state";
    exp_q.push_back(e0);
    @(negedge clk); rst = 1'b0;

    // R2/R3 code 0: single low sample fires
    step(1, 16'd50, 0, 1, "R3 code0 one sample");
    for (int i = 0; i < 3; i++) step(0, 16'd0, 0, 1, "R6 hold without clear");
    step(0, 16'd0, 1, 1, "R6 clear drops");
    // R2 bounds are inside; extremes
    step(1, 16'd100, 0, 1, "R2 equal low bound");
    step(1, 16'd200, 0, 1, "R2 equal high bound");
    step(1, 16'd201, 0, 1, "R2 above high bound");
    step(0, 16'd0, 1, 1, "R6 clear");
    step(1, 16'd150, 0, 1, "R2 inside");
    step(1, 16'hFFFF, 0, 1, "R2 max value");
    step(0, 16'd0, 1, 1, "R6 clear");
    cfg(16'd1, 16'd200, 2'd0);
    step(1, 16'd0, 0, 1, "R2 zero below low");
    step(0, 16'd0, 1, 1, "R6 clear");

    // R4 code 1: interrupted run
    cfg(16'd100, 16'd200, 2'd1);
    step(1, 16'd150, 0, 1, "R4 prime inside");
    for (int i = 0; i < 3; i++) step(1, 16'd300, 0, 1, "R3 code1 partial");
    step(1, 16'd150, 0, 1, "R4 inside resets");
    for (int i = 0; i < 3; i++) step(1, 16'd10, 0, 1, "R4 rerun partial");
    step(1, 16'd10, 0, 1, "R3 code1 fourth fires");
    step(0, 16'd0, 1, 1, "R6 clear");

    // R9 code 2 with idle gaps
    cfg(16'd100, 16'd200, 2'd2);
    step(1, 16'd150, 0, 1, "R4 prime inside");
    for (int i = 0; i < 8; i++) begin
      step(1, 16'd500, 0, 1, "R9 gapped sample");
      step(0, 16'd150, 0, 1, "R9 idle cycle");
    end
    step(0, 16'd0, 1, 1, "R6 clear");

    // R3 code 3: 15 no, 16 yes
    cfg(16'd100, 16'd200, 2'd3);
    step(1, 16'd150, 0, 1, "R4 prime inside");
    for (int i = 0; i < 15; i++) step(1, 16'd5, 0, 1, "R3 code3 below 16");
    step(1, 16'd5, 0, 1, "R3 code3 sixteenth");
    // R10 saturation: retrigger after clear
    step(0, 16'd0, 1, 1, "R6 clear");
    step(1, 16'd5, 0, 1, "R10 retrigger saturated");
    step(1, 16'd5, 0, 1, "R10 saturated again");
    step(0, 16'd0, 1, 1, "R6 clear");

    // R7 disable
    cfg(16'd100, 16'd200, 2'd1);
    for (int i = 0; i < 6; i++) step(1, 16'd999, 0, 0, "R7 disabled no trigger");
    for (int i = 0; i < 3; i++) step(1, 16'd999, 0, 1, "R7 needs full run");
    step(1, 16'd999, 0, 1, "R7 fourth after enable");
    step(0, 16'd0, 1, 1, "R6 clear");
    step(1, 16'd999, 0, 0, "R7 disable clears count");
    for (int i = 0; i < 3; i++) step(1, 16'd999, 0, 1, "R7 recount");

    // R8 clear and trigger together
    cfg(16'd100, 16'd200, 2'd0);
    step(1, 16'd150, 0, 1, "R4 prime inside");
    step(1, 16'd7, 1, 1, "R8 trigger beats clear");
    step(1, 16'd7, 1, 1, "R8 trigger beats clear set");
    step(0, 16'd0, 1, 1, "R6 clear");
    step(0, 16'd0, 0, 1, "R5 line idle high");

    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule